// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block sits in a host bridge and routes each access to the legacy area below one megabyte. Thirteen shadow regions cover the top 256 KiB of that area. Each region has a 4-bit attribute field, and those fields are packed two to a byte across seven configuration bytes. For a given address and direction, the block answers one question: does the access go to system RAM or to the PCI bus? A separate control byte governs the 128 KiB window that overlays legacy video memory. That window opens to RAM either when its open bit is set, or when the processor is in system management mode and the window's enable bit is set.

The configuration bytes are written through a byte-addressed port. One write carries up to four bytes. The routing answer is combinational from the address, the direction, the stored bytes and the SMM input. A one-cycle update pulse tells the rest of the chip to rebuild its memory map. The pulse follows any write that touches the attribute bytes or the window control byte, and any change of the SMM input.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset, all seven attribute bytes read 0x00 and the window control byte reads 0x02. Every decoded access then routes to PCI.
- R2: A write of `cfg_len_i` bytes (1 to 4) at `cfg_addr_i` stores byte k from `cfg_data_i[8k+7:8k]` at offset `cfg_addr_i+k`. Offsets 0x59 to 0x5F hold the attribute bytes and 0x72 holds the window control byte. `cfg_rdata_o` shows the byte stored at `cfg_addr_i`, and reads 0 at any other offset.
- R3: Region 0 spans 0xF0000 to 0xFFFFF. Regions 1 to 12 are 16 KiB each, in ascending order from 0xC0000. `hit_o` is 1 inside these regions and inside the window, and 0 elsewhere. When `hit_o` is 0, `to_ram_o` is 0.
- R4: Region i takes its field from offset 0x59+((i+1)/2), using integer division. Odd regions use bits 3:0 and even regions use bits 7:4, so region 0 uses bits 7:4 of 0x59.
- R5: Within a field, bit 0 sends reads to RAM and bit 1 sends writes to RAM. When the bit for the access direction is clear, the access goes to PCI.
- R6: The window 0xA0000 to 0xBFFFF routes both directions to RAM when bit 6 of the control byte is set.
- R7: When bit 6 is clear, the window routes to RAM only while `smm_i` is 1 and bit 3 is set. Otherwise it routes to PCI.
- R8: `upd_o` is high for exactly one cycle after a write whose byte range overlaps 0x59 to 0x5F or covers 0x72.
- R9: `upd_o` is high for one cycle after each change of `smm_i`.
- R10: A write that touches none of those offsets raises no `upd_o` and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_len_i | input | 3 | Bytes in the write, 1 to 4 |
| cfg_data_i | input | 32 | Write data, byte k in lane k |
| cfg_rdata_o | output | 8 | Stored byte at cfg_addr_i |
| smm_i | input | 1 | Processor in system management mode |
| mem_addr_i | input | 20 | Memory access address |
| mem_wr_i | input | 1 | 1 for write, 0 for read |
| hit_o | output | 1 | Address lies in a decoded range |
| to_ram_o | output | 1 | 1 routes to RAM, 0 routes to PCI |
| upd_o | output | 1 | One-cycle mapping update pulse |

## Verification
A wrong stored byte, or a wrong choice of nibble, shows up directly on `to_ram_o`. It appears in the same cycle as the first access to the affected region in the affected direction. For that reason the vector table visits both ends of the expansion range and both directions of regions that have mixed attributes. A lost or stuck update trigger shows up on `upd_o` in the cycle after the write or the SMM edge. The directed tests cover writes that just miss the ranges, writes that just overlap them, and a write that straddles into the window control byte.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int          NUM_REGIONS = 13;
  localparam int          PAM_BYTES   = 7;
  localparam logic [7:0]  PAM_OFF     = 8'h59;
  localparam logic [7:0]  WIN_OFF     = 8'h72;
  localparam logic [7:0]  WIN_RST     = 8'h02;
  localparam int          ADDR_W      = 20;
  localparam int          EXP_SHIFT   = 14;
  localparam logic [19:0] EXP_BASE    = 20'hC0000;
  localparam logic [3:0]  BIOS_TOP4   = 4'hF;
  localparam logic [2:0]  WIN_TOP3    = 3'b101;
  localparam int          WIN_OPEN_B  = 6;
  localparam int          WIN_EN_B    = 3;
  localparam int          LANES       = 4;
  typedef logic [PAM_BYTES-1:0][7:0] pam_t;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [7:0]           addr_i,
  input  logic [2:0]           len_i,
  input  logic [8*LANES-1:0]   data_i,
  input  logic                 smm_i,
  output pam_t                 pam_o,
  output logic [7:0]           win_o,
  output logic [7:0]           rdata_o,
  output logic                 upd_o
);
  pam_t                 pam_q;
  logic [7:0]           win_q;
  logic                 smm_q;
  logic [PAM_BYTES-1:0] pam_we;
  pam_t                 pam_wd;
  logic                 win_we;
  logic [7:0]           win_wd;

  always_comb begin
    pam_we = '0;
    pam_wd = pam_q;
    win_we = 1'b0;
    win_wd = win_q;
    for (int k = 0; k < LANES; k++) begin
      if (wr_i && (k < int'(len_i))) begin
        for (int j = 0; j < PAM_BYTES; j++) begin
          if ({1'b0, addr_i} + 9'(k) == {1'b0, PAM_OFF} + 9'(j)) begin
            pam_we[j] = 1'b1;
            pam_wd[j] = data_i[8*k +: 8];
          end
        end
        if ({1'b0, addr_i} + 9'(k) == {1'b0, WIN_OFF}) begin
          win_we = 1'b1;
          win_wd = data_i[8*k +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pam_q <= '0;
      win_q <= WIN_RST;
      smm_q <= 1'b0;
      upd_o <= 1'b0;
    end else begin
      for (int j = 0; j < PAM_BYTES; j++)
        if (pam_we[j]) pam_q[j] <= pam_wd[j];
      if (win_we) win_q <= win_wd;
      smm_q <= smm_i;
      upd_o <= (|pam_we) | win_we | (smm_i != smm_q);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int j = 0; j < PAM_BYTES; j++)
      if ({1'b0, addr_i} == {1'b0, PAM_OFF} + 9'(j)) rdata_o = pam_q[j];
    if (addr_i == WIN_OFF) rdata_o = win_q;
  end

  assign pam_o = pam_q;
  assign win_o = win_q;

  assert_smm_upd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smm_i != smm_q) |=> upd_o);
  assert_win_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i) |=> $stable(win_q) && $stable(pam_q));
endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
  import shadow_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pam_t              pam_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic              hit_o,
  output logic              ram_o
);
  localparam logic [ADDR_W-EXP_SHIFT-1:0] EXP_IDX = EXP_BASE[ADDR_W-1:EXP_SHIFT];

  logic [NUM_REGIONS-1:0] sel;
  logic [NUM_REGIONS-1:0] ram_v;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
    localparam int BYTE_IDX = (i + 1) / 2;
    logic [3:0] nib;
    if (i == 0) begin : g_bios
      assign sel[i] = (addr_i[ADDR_W-1 -: 4] == BIOS_TOP4);
    end else begin : g_exp
      assign sel[i] = (addr_i[ADDR_W-1:EXP_SHIFT] == EXP_IDX + (ADDR_W-EXP_SHIFT)'(i - 1));
    end
    if (i % 2 == 1) begin : g_lo
      assign nib = pam_i[BYTE_IDX][3:0];
    end else begin : g_hi
      assign nib = pam_i[BYTE_IDX][7:4];
    end
    assign ram_v[i] = sel[i] & (wr_i ? nib[1] : nib[0]);
  end

  assign hit_o = |sel;
  assign ram_o = |ram_v;

  assert_one_region_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
endmodule

// File: rtl/shadow_win_gate.sv
module shadow_win_gate
  import shadow_pkg::*;
(
  input  logic [7:0]        win_i,
  input  logic              smm_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              ram_o
);
  assign hit_o = (addr_i[ADDR_W-1 -: 3] == WIN_TOP3);
  assign ram_o = win_i[WIN_OPEN_B] | (smm_i & win_i[WIN_EN_B]);
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import shadow_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_wr_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [2:0]  cfg_len_i,
  input  logic [31:0] cfg_data_i,
  output logic [7:0]  cfg_rdata_o,
  input  logic        smm_i,
  input  logic [19:0] mem_addr_i,
  input  logic        mem_wr_i,
  output logic        hit_o,
  output logic        to_ram_o,
  output logic        upd_o
);
  pam_t       pam;
  logic [7:0] win;
  logic       reg_hit, reg_ram, win_hit, win_ram;

  shadow_cfg_regs i_regs (
    .clk_i, .rst_ni, .wr_i(cfg_wr_i), .addr_i(cfg_addr_i), .len_i(cfg_len_i),
    .data_i(cfg_data_i), .smm_i, .pam_o(pam), .win_o(win),
    .rdata_o(cfg_rdata_o), .upd_o
  );

  shadow_region_decode i_dec (
    .clk_i, .rst_ni, .pam_i(pam), .addr_i(mem_addr_i), .wr_i(mem_wr_i),
    .hit_o(reg_hit), .ram_o(reg_ram)
  );

  shadow_win_gate i_win (
    .win_i(win), .smm_i, .addr_i(mem_addr_i), .hit_o(win_hit), .ram_o(win_ram)
  );

  // window overrides region decode
  assign hit_o    = win_hit | reg_hit;
  assign to_ram_o = win_hit ? win_ram : reg_ram;

  assert_miss_pci_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> !to_ram_o);
  assert_win_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_hit && win[WIN_OPEN_B]) |-> to_ram_o);
  assert_win_closed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_hit && !win[WIN_OPEN_B] && !smm_i) |-> !to_ram_o);
endmodule

// File: tb/test_shadow_attr_decoder.sv
module test_shadow_attr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [2:0]  cfg_len = '0;
  logic [31:0] cfg_data = '0;
  logic [7:0]  cfg_rdata;
  logic        smm = 1'b0;
  logic [19:0] mem_addr = '0;
  logic        mem_wr = 1'b0;
  logic        hit, to_ram, upd;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  shadow_attr_decoder i_shadow_attr_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_len_i(cfg_len), .cfg_data_i(cfg_data), .cfg_rdata_o(cfg_rdata),
    .smm_i(smm), .mem_addr_i(mem_addr), .mem_wr_i(mem_wr),
    .hit_o(hit), .to_ram_o(to_ram), .upd_o(upd)
  );

  // {addr, wr, exp_hit, exp_ram}
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {20'hF0000, 1'b0, 1'b1, 1'b1}, {20'hF8000, 1'b1, 1'b1, 1'b0},
    {20'hC0000, 1'b0, 1'b1, 1'b1}, {20'hC3FFF, 1'b1, 1'b1, 1'b1},
    {20'hC4000, 1'b0, 1'b1, 1'b0}, {20'hC4000, 1'b1, 1'b1, 1'b1},
    {20'hC8000, 1'b0, 1'b1, 1'b1}, {20'hC8000, 1'b1, 1'b1, 1'b0},
    {20'hCC000, 1'b0, 1'b1, 1'b0}, {20'hE8000, 1'b1, 1'b1, 1'b1},
    {20'hE8000, 1'b0, 1'b1, 1'b0}, {20'hEC000, 1'b0, 1'b1, 1'b1},
    {20'hEFFFF, 1'b1, 1'b1, 1'b1}, {20'hA0000, 1'b0, 1'b1, 1'b0},
    {20'hBFFFF, 1'b1, 1'b1, 1'b0}, {20'h9FFFF, 1'b0, 1'b0, 1'b0},
    {20'h00000, 1'b1, 1'b0, 1'b0}, {20'hD0000, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [2:0] l, logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_len = l; cfg_data = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    cfg_addr = a; #1; v = cfg_rdata;
  endtask

  task automatic acc(logic [19:0] a, logic w);
    mem_addr = a; mem_wr = w; #1;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h72, v); chk("R1 win reset", {24'h0, v}, 32'h02);
    rd(8'h59, v); chk("R1 pam reset", {24'h0, v}, 32'h00);
    acc(20'hF0000, 1'b0); chk("R1 bios to pci", {31'h0, to_ram}, 32'h0);
    acc(20'hA0000, 1'b1); chk("R1 win to pci", {31'h0, to_ram}, 32'h0);
    chk("R1 no upd", {31'h0, upd}, 32'h0);

    // R2 R8 program attribute bytes
    cfg_write(8'h59, 3'd2, 32'h0000_2310);
    chk("R8 upd after pam write", {31'h0, upd}, 32'h1);
    @(negedge clk);
    chk("R8 upd one cycle", {31'h0, upd}, 32'h0);
    cfg_write(8'h5B, 3'd4, 32'h0000_0001);
    cfg_write(8'h5F, 3'd1, 32'h0000_0032);
    rd(8'h5A, v); chk("R2 lane1 stored", {24'h0, v}, 32'h23);
    rd(8'h5F, v); chk("R2 last byte", {24'h0, v}, 32'h32);

    // R3 R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][22:3], VEC[i][2]);
      chk("R3 hit", {31'h0, hit}, {31'h0, VEC[i][1]});
      chk("R4 R5 route", {31'h0, to_ram}, {31'h0, VEC[i][0]});
    end

    // R6 open bit
    cfg_write(8'h72, 3'd1, 32'h40);
    chk("R8 upd after win write", {31'h0, upd}, 32'h1);
    acc(20'hA0000, 1'b0); chk("R6 open rd", {31'h0, to_ram}, 32'h1);
    acc(20'hBFFFF, 1'b1); chk("R6 open wr", {31'h0, to_ram}, 32'h1);
    acc(20'hF0000, 1'b0); chk("R6 region unaffected", {31'h0, to_ram}, 32'h1);

    // R7 SMM gating
    cfg_write(8'h72, 3'd1, 32'h08);
    acc(20'hA8000, 1'b0); chk("R7 en no smm", {31'h0, to_ram}, 32'h0);
    @(negedge clk); smm = 1'b1; #1;
    chk("R7 en smm", {31'h0, to_ram}, 32'h1);
    @(negedge clk);
    chk("R9 upd smm rise", {31'h0, upd}, 32'h1);
    @(negedge clk);
    chk("R9 upd one cycle", {31'h0, upd}, 32'h0);
    cfg_write(8'h72, 3'd1, 32'h00);
    acc(20'hA8000, 1'b1); chk("R7 smm no en", {31'h0, to_ram}, 32'h0);
    @(negedge clk); smm = 1'b0;
    @(negedge clk);
    chk("R9 upd smm fall", {31'h0, upd}, 32'h1);

    // R10 writes beside the ranges
    @(negedge clk);
    cfg_write(8'h60, 3'd1, 32'hFF);
    chk("R10 no upd 0x60", {31'h0, upd}, 32'h0);
    rd(8'h60, v); chk("R10 0x60 reads 0", {24'h0, v}, 32'h0);
    cfg_write(8'h55, 3'd4, 32'hFFFF_FFFF);
    chk("R10 no upd 0x55", {31'h0, upd}, 32'h0);
    cfg_write(8'h70, 3'd2, 32'hFFFF);
    chk("R10 no upd 0x70", {31'h0, upd}, 32'h0);
    rd(8'h72, v); chk("R10 win kept", {24'h0, v}, 32'h00);
    rd(8'h59, v); chk("R10 pam kept", {24'h0, v}, 32'h10);

    // R8 straddling writes
    cfg_write(8'h56, 3'd4, 32'h3000_0000);
    chk("R8 upd straddle pam", {31'h0, upd}, 32'h1);
    rd(8'h59, v); chk("R2 lane3 stored", {24'h0, v}, 32'h30);
    acc(20'hF4000, 1'b1); chk("R5 bios write", {31'h0, to_ram}, 32'h1);
    cfg_write(8'h70, 3'd4, 32'h0040_0000);
    chk("R8 upd straddle win", {31'h0, upd}, 32'h1);
    rd(8'h72, v); chk("R2 lane2 win", {24'h0, v}, 32'h40);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0; #1;
    rd(8'h5F, v); chk("R1 async reset pam", {24'h0, v}, 32'h0);
    acc(20'hA0000, 1'b0); chk("R1 async reset win", {31'h0, to_ram}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule